// File: doc/BRIEF.md
# Dual-Lane Byte Channel Serializer

This block takes one 128-bit word from a memory core and sends it out over a channel two bytes wide. The word is split into two 64-bit halves. Each half feeds its own byte lane and is sent one byte per beat, with the least significant byte first. Both lanes move in lockstep, and together they form a 16-bit channel.

The channel transfers data on both clock edges. In synthesizable logic this is modelled as two beats per clock cycle. Each lane port carries the rising-edge beat in bits [7:0] and the falling-edge beat in bits [15:8]. A full word therefore takes four clock cycles. The upstream side uses a valid/ready handshake. The next word can be accepted in the last cycle of the current one, so back-to-back words stream with no gap.

Top module: `dual_lane_serializer`

## Requirements
- R1: While rst_ni is low, and directly after it rises, beat_valid_o and last_o are 0 and word_ready_o is 1.
- R2: When idle, word_ready_o is 1. A word is accepted at a rising edge where word_valid_i and word_ready_o are both 1. beat_valid_o is then 1 for exactly the next 4 cycles.
- R3: In stream cycle n (n = 0..3):
  - lane_a_o[7:0] carries byte 2n of the word and lane_a_o[15:8] carries byte 2n+1. Byte k is word_i[8k+7:8k].
  - lane_b_o carries the same byte positions taken from the high half, word_i[127:64].
  - So lane_a_o equals word[16n+15:16n] and lane_b_o equals word[64+16n+15:64+16n].
- R4: last_o is 1 only in the fourth stream cycle, the one that carries byte 7 of each lane, and only while beat_valid_o is 1.
- R5: word_ready_o is 0 in stream cycles 0 to 2 and 1 in stream cycle 3.
- R6: A word accepted in stream cycle 3 starts its stream cycle 0 in the next cycle, with no idle cycle between the two words.
- R7: While word_ready_o is 0, word_valid_i and word_i have no effect: the current stream is unchanged and no word is queued.
- R8: When idle, or in stream cycle 3, with word_valid_i low, beat_valid_o is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 128 | Wide core word |
| word_valid_i | input | 1 | word_i is valid |
| word_ready_o | output | 1 | Block can accept a word |
| lane_a_o | output | 16 | Lane A beat pair: [7:0] rising-edge beat, [15:8] falling-edge beat |
| lane_b_o | output | 16 | Lane B beat pair, same layout as lane A |
| beat_valid_o | output | 1 | The lane beat pair is valid |
| last_o | output | 1 | This beat pair carries the final byte on each lane |

## Verification
The bound checker checks the following on every cycle:
- the handshake and framing rules: a stream starts after each acceptance, runs for four cycles, places last on the fourth, drops ready only mid-stream, and falls idle when no word is offered.

Byte ordering and lane mapping depend on the data values, so only the bench can show them. The bench compares each beat pair against the word it drove. Three properties also need the bench's directed scenarios:
- junk offered mid-stream is ignored;
- a chained word follows with no gap;
- the reset values are correct.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dls_ctrl.sv
module dls_ctrl #(
  parameter int unsigned PAIRS = 4,
  localparam int unsigned CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] pair_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign last_o   = busy_q && (cnt_q == CNT_W'(PAIRS - 1));
  assign ready_o  = !busy_q || last_o;
  assign accept_o = valid_i && ready_o;
  assign busy_o   = busy_q;
  assign pair_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dls_lane.sv
module dls_lane
  import dls_pkg::*;
#(
  parameter int unsigned LANE_BYTES = 8,
  parameter int unsigned BEATS      = 2,
  parameter int unsigned CNT_W      = 2,
  localparam int unsigned IDX_W     = $clog2(LANE_BYTES)
) (
  input  logic [LANE_BYTES*BYTE_W-1:0] half_i,
  input  logic [CNT_W-1:0]             pair_i,
  output logic [BEATS*BYTE_W-1:0]      beats_o
);
  byte_t bytes [LANE_BYTES];

  for (genvar k = 0; k < LANE_BYTES; k++) begin : g_split
    assign bytes[k] = half_i[k*BYTE_W +: BYTE_W];
  end

  // beat b of pair p uses byte p*BEATS+b
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic [IDX_W-1:0] idx;
    always_comb idx = IDX_W'(pair_i) * IDX_W'(BEATS) + IDX_W'(b);
    assign beats_o[b*BYTE_W +: BYTE_W] = bytes[idx];
  end
endmodule

// File: rtl/dual_lane_serializer.sv
module dual_lane_serializer
  import dls_pkg::*;
#(
  parameter int unsigned LANE_BYTES = 8,
  parameter int unsigned BEATS      = 2,
  localparam int unsigned LANES     = 2,
  localparam int unsigned HALF_W    = LANE_BYTES * BYTE_W,
  localparam int unsigned WORD_W    = LANES * HALF_W,
  localparam int unsigned PAIR_W    = BEATS * BYTE_W,
  localparam int unsigned PAIRS     = LANE_BYTES / BEATS,
  localparam int unsigned CNT_W     = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic [PAIR_W-1:0] lane_a_o,
  output logic [PAIR_W-1:0] lane_b_o,
  output logic              beat_valid_o,
  output logic              last_o
);
  logic              accept;
  logic [CNT_W-1:0]  pair;
  logic [WORD_W-1:0] word_q;
  logic [PAIR_W-1:0] lane_beats [LANES];

  dls_ctrl #(.PAIRS(PAIRS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (word_valid_i),
    .ready_o  (word_ready_o),
    .accept_o (accept),
    .busy_o   (beat_valid_o),
    .last_o   (last_o),
    .pair_o   (pair)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (accept) word_q <= word_i;
  end

  // lane 0 = low half, lane 1 = high half
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dls_lane #(
      .LANE_BYTES (LANE_BYTES),
      .BEATS      (BEATS),
      .CNT_W      (CNT_W)
    ) u_lane (
      .half_i  (word_q[l*HALF_W +: HALF_W]),
      .pair_i  (pair),
      .beats_o (lane_beats[l])
    );
  end

  assign lane_a_o = lane_beats[0];
  assign lane_b_o = lane_beats[1];
endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int unsigned PAIRS = 4,
  localparam int unsigned RUN_W = $clog2(PAIRS) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic word_valid_i,
  input logic word_ready_o,
  input logic beat_valid_o,
  input logic last_o
);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (beat_valid_o) run_q <= last_o ? '0 : run_q + 1'b1;
  end

  assert_last_in_stream_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> beat_valid_o);

  assert_last_position_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> (last_o == (run_q == RUN_W'(PAIRS - 1))));

  assert_busy_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !last_o) |-> !word_ready_o);

  assert_idle_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_o |-> word_ready_o);

  assert_accept_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> (beat_valid_o && run_q == '0));

  assert_stream_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !last_o) |=> beat_valid_o);

  assert_chain_no_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && word_valid_i) |=> (beat_valid_o && !last_o));

  assert_quiet_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!beat_valid_o || last_o) && !word_valid_i) |=> !beat_valid_o);
endmodule

bind dual_lane_serializer dls_chk #(.PAIRS(PAIRS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .beat_valid_o (beat_valid_o),
  .last_o       (last_o)
);

// File: tb/dual_lane_serializer_test.sv
module dual_lane_serializer_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [127:0] word_i = '0;
  logic         word_valid_i = 1'b0;
  logic         word_ready_o;
  logic [15:0]  lane_a_o;
  logic [15:0]  lane_b_o;
  logic         beat_valid_o;
  logic         last_o;

  int checks = 0;
  int errors = 0;

  localparam logic [127:0] VEC [5] = '{
    128'h0f0e0d0c0b0a09080706050403020100,
    128'hffeeddccbbaa99887766554433221100,
    128'h00000000000000000000000000000000,
    128'hffffffffffffffffffffffffffffffff,
    128'h5a3c96e1_0123_4567_89ab_cdef_deadbeef
  };

  dual_lane_serializer uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_i       (word_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .lane_a_o     (lane_a_o),
    .lane_b_o     (lane_b_o),
    .beat_valid_o (beat_valid_o),
    .last_o       (last_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive word at a negedge; returns at the negedge showing pair 0
  task automatic start(input logic [127:0] w);
    word_i       = w;
    word_valid_i = 1'b1;
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  // called at pair-0 negedge; returns at pair-3 negedge
  task automatic check_stream(input logic [127:0] w, input bit junk, input bit chain, input logic [127:0] nxt);
    for (int n = 0; n < 4; n++) begin
      chk(beat_valid_o == 1'b1, "R2", 128'(beat_valid_o), 128'd1);
      chk(lane_a_o == w[16*n +: 16], "R3", 128'(lane_a_o), 128'(w[16*n +: 16]));
      chk(lane_b_o == w[64+16*n +: 16], "R3", 128'(lane_b_o), 128'(w[64+16*n +: 16]));
      chk(last_o == (n == 3), "R4", 128'(last_o), 128'(n == 3));
      chk(word_ready_o == (n == 3), "R5", 128'(word_ready_o), 128'(n == 3));
      if (junk) begin  // R7: offers while ready is low
        word_i       = ~w;
        word_valid_i = (n < 2);
      end
      if (n < 3) @(negedge clk_i);
    end
    if (chain) begin
      word_i       = nxt;
      word_valid_i = 1'b1;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R1", 128'(beat_valid_o), 128'd0);
    chk(last_o == 1'b0, "R1", 128'(last_o), 128'd0);
    chk(word_ready_o == 1'b1, "R1", 128'(word_ready_o), 128'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0 && word_ready_o == 1'b1, "R1", 128'({beat_valid_o, word_ready_o}), 128'b01);

    // table walk
    for (int i = 0; i < 5; i++) begin
      chk(word_ready_o == 1'b1, "R2", 128'(word_ready_o), 128'd1);
      start(VEC[i]);
      check_stream(VEC[i], 1'b0, 1'b0, '0);
      @(negedge clk_i);
      chk(beat_valid_o == 1'b0, "R8", 128'(beat_valid_o), 128'd0);
    end

    // R8: stays idle with no offer
    repeat (3) @(negedge clk_i);
    chk(beat_valid_o == 1'b0 && last_o == 1'b0, "R8", 128'({beat_valid_o, last_o}), 128'd0);

    // R7: junk offered mid-stream is ignored and not queued
    start(VEC[1]);
    check_stream(VEC[1], 1'b1, 1'b0, '0);
    word_valid_i = 1'b0;
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R7", 128'(beat_valid_o), 128'd0);

    // R6: back-to-back chain of three words
    start(VEC[0]);
    check_stream(VEC[0], 1'b0, 1'b1, VEC[4]);
    @(negedge clk_i);
    word_valid_i = 1'b0;
    chk(beat_valid_o == 1'b1 && last_o == 1'b0, "R6", 128'({beat_valid_o, last_o}), 128'b10);
    check_stream(VEC[4], 1'b0, 1'b1, VEC[1]);
    @(negedge clk_i);
    word_valid_i = 1'b0;
    chk(lane_a_o == VEC[1][15:0], "R6", 128'(lane_a_o), 128'(VEC[1][15:0]));
    check_stream(VEC[1], 1'b0, 1'b0, '0);
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R8", 128'(beat_valid_o), 128'd0);

    // R1: reset mid-stream
    start(VEC[3]);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(beat_valid_o == 1'b0 && last_o == 1'b0 && word_ready_o == 1'b1, "R1",
        128'({beat_valid_o, last_o, word_ready_o}), 128'b001);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(beat_valid_o == 1'b0, "R1", 128'(beat_valid_o), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule